// File: doc/BRIEF.md
# Pixel Output Lane Splitter

The block sits behind a pixel digitizer and takes one sample per pixel clock. A line-start flag marks the sample that was taken on the leading edge of horizontal sync. The block spreads the samples over two output ports, A and B. In single-lane mode every sample leaves on port A and port B is switched off. Port B's high-impedance state is shown by an output-enable pin that is low. In dual-lane mode the samples are grouped in pairs, and both ports load one pair together on every second sample. A swap control chooses which port carries the first sample of each pair.

The pairing phase is re-anchored at every line start. The line-start sample is always the first sample of a pair. A line start that arrives while a pair is half filled discards the held sample. The mode and swap controls are read only on the line-start sample, so a change in the middle of a line never breaks a pair. The block also provides a data clock whose rising edge falls between port-A updates, a sync output that travels with the data, and a valid strobe. The valid strobe stays low while the output pipeline is flushed after reset or after a change of mode.

Both streams are fixed-rate and carry no back-pressure. The input is a valid-qualified stream without a ready: every sample offered with `s_valid` high is accepted on that clock edge. The output is a valid strobe without a ready: the receiver must take each update in the cycle it is shown.

Top module: `px_lane_split`

## Requirements
- R1: During and after reset, and until the first update, `m_valid`, `hs_out` and `b_oe` are 0 and both ports read 0.
- R2: Samples offered before the first accepted line start are discarded and produce no update. Cycles with `s_valid` low neither advance nor disturb the pairing.
- R3: In single-lane mode, each accepted sample appears on `a_data` in the cycle after it is accepted, and `b_oe` is 0. `cfg_swap` has no effect in this mode.
- R4: In dual-lane mode, `b_oe` is 1. The line-start sample and every second sample after it open a pair. When the following sample is accepted, both ports load in the next cycle. With `cfg_swap`=0 the first sample of the pair goes to A and the second to B. With `cfg_swap`=1 the first goes to B and the second to A.
- R5: `cfg_dual` and `cfg_swap` are read only on an accepted line-start sample (`s_valid` and `s_line_start` both 1). Changes at any other time have no effect until the next line start, and `b_oe` changes only in the cycle after such a sample.
- R6: A line start that arrives while a pair holds only its first sample drops that held sample. The line-start sample opens a new pair.
- R7: After reset, and after every line start that changes the mode, the first 4 port updates in single-lane mode and the first 2 pair updates in dual-lane mode have `m_valid`=0. The following updates have `m_valid`=1.
- R8: `hs_out` is 1 for exactly the one cycle in which the ports show the update that contains the line-start sample.
- R9: In dual-lane mode, `dclk` is 0 in every cycle that shows a pair update and 1 in the cycle after it, so its rising edge falls midway between updates. In single-lane mode, `dclk` is the inverted pixel clock, so it rises midway between port-A updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample present this cycle |
| s_data | input | DATA_W | Digitized sample |
| s_line_start | input | 1 | Sample was taken on the sync leading edge |
| cfg_dual | input | 1 | 1 = dual-lane mode, 0 = single-lane mode |
| cfg_swap | input | 1 | 1 = first sample of each pair goes to port B |
| a_data | output | DATA_W | Port A data |
| b_data | output | DATA_W | Port B data |
| b_oe | output | 1 | Port B drive enable (0 = high impedance) |
| m_valid | output | 1 | Ports carry a valid update this cycle |
| hs_out | output | 1 | Sync pulse aligned with the line-start update |
| dclk | output | 1 | Output data clock |

## Verification
In single-lane mode a port update is due one clock after the sample is accepted. In dual-lane mode a pair update is due one clock after its second sample is accepted, and `dclk` returns high one clock after that. `b_oe` follows one clock after an accepted line start. The bench drives its inputs 1 ns after a rising edge and samples the outputs 3 ns after a rising edge, so each result is read in the cycle after the edge that produced it. Expected updates are queued when the sample that completes them is driven and are taken off the queue on each `m_valid` strobe. The flush windows and the discarded samples are checked by counting strobes over whole lines.

// File: rtl/px_lane_pkg.sv
`timescale 1ns/1ps
package px_lane_pkg;

  // One step decision from the pairing sequencer to the output registers.
  typedef struct packed {
    logic upd;   // ports load this cycle
    logic load;  // sample is parked as first half of a pair
    logic tag;   // the update carries the line-start sample
  } step_t;

  function automatic int max_of(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/px_lane_seq.sv
`timescale 1ns/1ps
module px_lane_seq
  import px_lane_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  s_valid,
  input  logic  s_line_start,
  input  logic  cfg_dual,
  input  logic  cfg_swap,
  output step_t step,
  output logic  restart,
  output logic  eff_dual,
  output logic  swap_q,
  output logic  mode_q
);

  logic aligned_q;
  logic slot_q;
  logic start_q;
  logic accept;
  logic second;
  logic ls_take;

  assign ls_take  = s_valid && s_line_start;
  assign accept   = s_valid && (aligned_q || s_line_start);
  // the line-start sample applies the new mode to itself
  assign eff_dual = s_line_start ? cfg_dual : mode_q;
  assign second   = !s_line_start && slot_q;
  assign restart  = ls_take && (cfg_dual != mode_q);

  always_comb begin
    step.upd  = accept && (!eff_dual || second);
    step.load = accept && eff_dual && !second;
    step.tag  = eff_dual ? start_q : s_line_start;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aligned_q <= 1'b0;
      mode_q    <= 1'b0;
      swap_q    <= 1'b0;
      slot_q    <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      if (ls_take) begin
        aligned_q <= 1'b1;
        mode_q    <= cfg_dual;
        swap_q    <= cfg_swap;
      end
      if (accept) begin
        slot_q <= step.load;
      end
      if (step.load) begin
        start_q <= s_line_start;
      end
    end
  end

endmodule

// File: rtl/px_lane_flush.sv
`timescale 1ns/1ps
module px_lane_flush
  import px_lane_pkg::*;
#(
  parameter int FLUSH_SINGLE = 4,
  parameter int FLUSH_DUAL   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic restart,
  input  logic dual_sel,
  output logic upd_ok
);

  localparam int LIM_MAX = max_of(FLUSH_SINGLE, FLUSH_DUAL);
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] limit;

  assign base   = restart ? '0 : cnt_q;
  assign limit  = dual_sel ? CNT_W'(FLUSH_DUAL) : CNT_W'(FLUSH_SINGLE);
  assign upd_ok = (base >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (upd && (base < CNT_W'(LIM_MAX))) begin
      cnt_q <= base + 1'b1;
    end else begin
      cnt_q <= base;
    end
  end

endmodule

// File: rtl/px_lane_regs.sv
`timescale 1ns/1ps
module px_lane_regs
  import px_lane_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_t             step,
  input  logic [DATA_W-1:0] sample,
  input  logic              swap,
  input  logic              dual_sel,
  input  logic              upd_ok,
  output logic [DATA_W-1:0] lane_a,
  output logic [DATA_W-1:0] lane_b,
  output logic              hs_q,
  output logic              mv_q,
  output logic              dclk_q
);

  localparam int NLANE = 2;

  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] lane_q [NLANE];

  for (genvar p = 0; p < NLANE; p++) begin : g_lane
    logic [DATA_W-1:0] nxt;
    logic              we;
    // the lane whose index equals the swap bit takes the parked first sample
    assign nxt = (dual_sel && (swap == 1'(p))) ? hold_q : sample;
    assign we  = step.upd && (dual_sel || (p == 0));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lane_q[p] <= '0;
      end else if (we) begin
        lane_q[p] <= nxt;
      end
    end
  end

  assign lane_a = lane_q[0];
  assign lane_b = lane_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      hs_q   <= 1'b0;
      mv_q   <= 1'b0;
      dclk_q <= 1'b1;
    end else begin
      if (step.load) begin
        hold_q <= sample;
      end
      hs_q   <= step.upd && step.tag;
      mv_q   <= step.upd && upd_ok;
      dclk_q <= !(step.upd && dual_sel);
    end
  end

endmodule

// File: rtl/px_lane_split.sv
`timescale 1ns/1ps
module px_lane_split
  import px_lane_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int FLUSH_SINGLE = 4,
  parameter int FLUSH_DUAL   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_line_start,
  input  logic              cfg_dual,
  input  logic              cfg_swap,
  output logic [DATA_W-1:0] a_data,
  output logic [DATA_W-1:0] b_data,
  output logic              b_oe,
  output logic              m_valid,
  output logic              hs_out,
  output logic              dclk
);

  step_t step;
  logic  restart;
  logic  eff_dual;
  logic  swap_q;
  logic  mode_q;
  logic  upd_ok;
  logic  dclk_q;

  px_lane_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .s_valid      (s_valid),
    .s_line_start (s_line_start),
    .cfg_dual     (cfg_dual),
    .cfg_swap     (cfg_swap),
    .step         (step),
    .restart      (restart),
    .eff_dual     (eff_dual),
    .swap_q       (swap_q),
    .mode_q       (mode_q)
  );

  px_lane_flush #(
    .FLUSH_SINGLE (FLUSH_SINGLE),
    .FLUSH_DUAL   (FLUSH_DUAL)
  ) u_flush (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (step.upd),
    .restart  (restart),
    .dual_sel (eff_dual),
    .upd_ok   (upd_ok)
  );

  px_lane_regs #(
    .DATA_W (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .sample   (s_data),
    .swap     (swap_q),
    .dual_sel (eff_dual),
    .upd_ok   (upd_ok),
    .lane_a   (a_data),
    .lane_b   (b_data),
    .hs_q     (hs_out),
    .mv_q     (m_valid),
    .dclk_q   (dclk_q)
  );

  assign b_oe = mode_q;
  assign dclk = mode_q ? dclk_q : ~clk;

endmodule

// File: rtl/px_lane_split_chk.sv
`timescale 1ns/1ps
module px_lane_split_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_line_start,
  input logic b_oe,
  input logic m_valid,
  input logic hs_out,
  input logic dclk
);

  assert_single_follows_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !b_oe) |-> $past(s_valid));

  assert_pair_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && b_oe) |=> !m_valid);

  assert_oe_moves_at_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(b_oe) |-> $past(s_valid && s_line_start));

  assert_sync_after_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_out && !b_oe) |-> $past(s_valid && s_line_start));

  assert_dclk_low_on_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && b_oe) |-> !dclk);

  assert_dclk_rises_after_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && b_oe) |=> (dclk || !b_oe));

endmodule

bind px_lane_split px_lane_split_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .s_valid      (s_valid),
  .s_line_start (s_line_start),
  .b_oe         (b_oe),
  .m_valid      (m_valid),
  .hs_out       (hs_out),
  .dclk         (dclk)
);

// File: tb/px_lane_split_tb_top.sv
`timescale 1ns/1ps
module px_lane_split_tb_top;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic          s_line_start = 1'b0;
  logic          cfg_dual = 1'b0;
  logic          cfg_swap = 1'b0;
  logic [DW-1:0] a_data;
  logic [DW-1:0] b_data;
  logic          b_oe;
  logic          m_valid;
  logic          hs_out;
  logic          dclk;

  always #2 clk = ~clk;

  px_lane_split #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .s_line_start(s_line_start), .cfg_dual(cfg_dual), .cfg_swap(cfg_swap),
    .a_data(a_data), .b_data(b_data), .b_oe(b_oe), .m_valid(m_valid),
    .hs_out(hs_out), .dclk(dclk)
  );

  typedef struct {
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic          hs;
    logic          has_b;
    string         req;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  int   seen  = 0;
  bit   mon_on = 1'b0;

  // reference state
  bit          m_aligned = 0;
  bit          m_dual = 0;
  bit          m_swap = 0;
  bit          m_slot = 0;
  logic [DW-1:0] m_hold = '0;
  bit          m_hold_ls = 0;
  int          m_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one sample and push the update it completes
  task automatic send(input logic [DW-1:0] d, input bit ls, input string req);
    exp_t e;
    bit   ok;
    @(posedge clk); #1;
    s_valid = 1'b1; s_data = d; s_line_start = ls;
    if (ls) begin
      if (cfg_dual != m_dual) m_cnt = 0;
      m_dual = cfg_dual; m_swap = cfg_swap; m_aligned = 1;
    end
    if (!m_aligned) return;
    if (!m_dual) begin
      ok = (m_cnt >= 4);
      m_cnt++;
      m_slot = 0;
      if (ok) begin
        e.a = d; e.b = '0; e.hs = ls; e.has_b = 0; e.req = req;
        exp_q.push_back(e);
      end
    end else if (ls || !m_slot) begin
      m_hold = d; m_hold_ls = ls; m_slot = 1;
    end else begin
      ok = (m_cnt >= 2);
      m_cnt++;
      m_slot = 0;
      if (ok) begin
        e.a = m_swap ? d : m_hold;
        e.b = m_swap ? m_hold : d;
        e.hs = m_hold_ls; e.has_b = 1; e.req = req;
        exp_q.push_back(e);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      s_valid = 1'b0; s_line_start = 1'b0;
    end
  endtask

  task automatic line(input logic [DW-1:0] first, input int n, input string req);
    for (int i = 0; i < n; i++) send(first + DW'(i), (i == 0), req);
  endtask

  // monitor: 3 ns after each rising edge
  bit prev_pair = 0;
  always begin
    @(posedge clk); #3;
    if (mon_on) begin
      if (prev_pair && !m_valid && b_oe)
        chk(dclk == 1'b1, "R9", "dclk high after pair", dclk, 1);
      prev_pair = m_valid && b_oe;
      if (m_valid) begin
        seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected update a_data", a_data, -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(a_data == e.a, e.req, "a_data", a_data, e.a);
          chk(hs_out == e.hs, "R8", "hs_out", hs_out, e.hs);
          if (e.has_b) begin
            chk(b_data == e.b, e.req, "b_data", b_data, e.b);
            chk(dclk == 1'b0, "R9", "dclk low on pair", dclk, 0);
          end
        end
      end
    end
  end

  bit finished = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  int base;
  initial begin
    repeat (3) @(posedge clk);
    #3;
    // R1 during reset
    chk(m_valid == 0 && hs_out == 0, "R1", "strobes in reset", m_valid, 0);
    chk(b_oe == 0, "R1", "b_oe in reset", b_oe, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #2;
    chk(a_data == 0 && b_data == 0, "R1", "ports after reset", a_data, 0);
    mon_on = 1'b1;

    // R2: nothing before the first line start
    send(8'hE1, 0, "R2"); idle(1); send(8'hE2, 0, "R2"); send(8'hE3, 0, "R2");
    idle(3);
    chk(seen == 0, "R2", "updates before alignment", seen, 0);

    // R7 + R3: first single line, 4 flush updates
    base = seen;
    line(8'd10, 12, "R3");
    idle(3);
    chk(seen - base == 8, "R7", "single flush strobes", seen - base, 8);

    // R3 with gaps, swap ignored in single mode
    cfg_swap = 1'b1;
    base = seen;
    send(8'd30, 1, "R3"); idle(1); send(8'd31, 0, "R3"); send(8'd32, 0, "R3");
    idle(2); send(8'd33, 0, "R3"); idle(3);
    chk(seen - base == 4, "R2", "gapped single strobes", seen - base, 4);
    chk(b_oe == 0, "R3", "b_oe single", b_oe, 0);
    // R9 single: dclk is the inverted pixel clock
    @(posedge clk); #1;
    chk(dclk == 0, "R9", "single dclk high phase", dclk, 0);
    #2;
    chk(dclk == 1, "R9", "single dclk low phase", dclk, 1);

    // R4 + R7: switch to dual, swap off
    cfg_dual = 1'b1; cfg_swap = 1'b0;
    base = seen;
    line(8'd40, 8, "R4");
    idle(3);
    chk(seen - base == 2, "R7", "dual flush strobes", seen - base, 2);
    chk(b_oe == 1, "R4", "b_oe dual", b_oe, 1);

    // R4 swap on; R5 mid-line control changes ignored
    cfg_swap = 1'b1;
    send(8'd50, 1, "R4"); send(8'd51, 0, "R4"); send(8'd52, 0, "R4");
    cfg_swap = 1'b0; cfg_dual = 1'b0;
    send(8'd53, 0, "R5"); send(8'd54, 0, "R5"); send(8'd55, 0, "R5");
    idle(3);
    chk(b_oe == 1, "R5", "b_oe held mid-line", b_oe, 1);

    // R6: line start on an odd slot drops the parked sample
    cfg_dual = 1'b1; cfg_swap = 1'b0;
    base = seen;
    send(8'd60, 1, "R6"); send(8'd61, 0, "R6"); send(8'd62, 0, "R6");
    send(8'd63, 1, "R6"); send(8'd64, 0, "R6"); send(8'd65, 0, "R6");
    send(8'd66, 0, "R6");
    idle(3);
    chk(seen - base == 3, "R6", "pairs after realign", seen - base, 3);

    // R7: back to single restarts the flush
    cfg_dual = 1'b0;
    base = seen;
    line(8'd70, 10, "R7");
    idle(3);
    chk(seen - base == 6, "R7", "flush after mode change", seen - base, 6);
    chk(b_oe == 0, "R5", "b_oe after return", b_oe, 0);

    chk(exp_q.size() == 0, "R4", "pending expected items", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule